// File: doc/BRIEF.md
# Mixed-Sign Split Multiplier Slice

This block is an 18×18 multiplier slice in which the signedness of each operand is picked at run time by its own control input. It can be built as one full-width 18×18 multiply, or as two independent 9×9 multiplies that run side by side on the low and high halves of the operands. The product always carries full precision: 36 bits in the wide mode, and two 18-bit products in the split mode.

Each operand, together with its sign control, can go through an optional input register. Each operand's register is chosen by its own parameter. The product can pass through an optional output register. In the split mode that register is made of two 18-bit sections, and in the wide mode it is one 36-bit section. All registers share one clock, one clock enable and one asynchronous clear. Depending on which registers are built, the latency from an operand to the product is 0, 1 or 2 cycles. If the sign controls are configured as unused, both operands are treated as unsigned.

Top module: `mul_slice`

## Requirements
- R1: When `a_signed_i` is 1, operand A is read as a two's-complement number, and when it is 0, A is read as unsigned. `b_signed_i` does the same for operand B.
- R2: In wide mode, `prod_o[35:0]` is the exact product of the two 18-bit operands for all four sign combinations. The result is signed whenever at least one operand is signed.
- R3: In split mode, `prod_o[17:0]` is the exact product of `a_i[8:0]` and `b_i[8:0]`, and `prod_o[35:18]` is the exact product of `a_i[17:9]` and `b_i[17:9]`. Both halves use the same two sign controls.
- R4: Each operand and its sign control are registered or bypassed as a pair, and this is chosen separately for A and for B. A registered operand reaches the product one clock edge after it is applied. A bypassed operand reaches the product in the same cycle.
- R5: When the output register is built, it adds exactly one clock edge of latency. With both input registers and the output register built, a new operand pair appears at `prod_o` after the second rising edge.
- R6: While `ena_i` is 0, every register holds its value, so a registered `prod_o` does not change even when the inputs change.
- R7: While `clr_i` is 1, all registers go to zero at once, without waiting for a clock edge. A registered `prod_o` reads 0, and so does a product fed from cleared input registers.
- R8: When the sign controls are configured as unused (`USE_SIGN` = 0), the sign inputs are ignored and both operands are multiplied as unsigned.
- R9: A zero operand gives an all-zero product in every sign combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for every register in the slice |
| clr_i | input | 1 | Asynchronous clear, active high |
| ena_i | input | 1 | Clock enable shared by all registers |
| a_i | input | 18 | Operand A |
| b_i | input | 18 | Operand B |
| a_signed_i | input | 1 | 1: A is signed; 0: A is unsigned |
| b_signed_i | input | 1 | 1: B is signed; 0: B is unsigned |
| prod_o | output | 36 | Full-precision product, or two 18-bit products in split mode |

## Verification
A wrong extension bit inside the multiplier appears at `prod_o` as a wrong upper part of the product. This is visible only when a negative operand meets the wrong sign setting, so operands with their top bit set are run through all four sign combinations, including the most negative value squared. A sign register that is misaligned with its operand register shows up one edge after a sign change, as the product of new data with an old sign. A held or cleared register that leaks shows up on the first edge after `ena_i` drops, or at once while `clr_i` is high. In split mode, a carry crossing between the lanes corrupts bit 18 upward as soon as the low lane's product goes negative.

// File: rtl/mul_slice_pkg.sv
package mul_slice_pkg;
    // Default operand width of the slice and widths derived from it
    localparam int OP_W   = 18;
    localparam int HALF_W = OP_W / 2;
    localparam int PROD_W = 2 * OP_W;

    // Multiplier arrangement
    typedef enum logic {
        MODE_WIDE  = 1'b0,   // one OP_W x OP_W product
        MODE_SPLIT = 1'b1    // two HALF_W x HALF_W products in parallel
    } mul_mode_e;
endpackage

// File: rtl/mul_in_reg.sv
// Optional input register for one operand together with its sign control.
module mul_in_reg #(
    parameter int W        = 18,
    parameter bit REGISTER = 1'b1
) (
    input  logic         clk_i,
    input  logic         clr_i,
    input  logic         ena_i,
    input  logic [W-1:0] data_i,
    input  logic         sgn_i,
    output logic [W-1:0] data_o,
    output logic         sgn_o
);
    generate
        if (REGISTER) begin : g_reg
            typedef struct packed {
                logic [W-1:0] data;
                logic         sgn;
            } stage_t;

            stage_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (ena_i) begin
                    st_d.data = data_i;
                    st_d.sgn  = sgn_i;
                end
            end

            always_ff @(posedge clk_i or posedge clr_i) begin
                if (clr_i) st_q <= '0;
                else       st_q <= st_d;
            end

            assign data_o = st_q.data;
            assign sgn_o  = st_q.sgn;
        end else begin : g_bypass
            assign data_o = data_i;
            assign sgn_o  = sgn_i;
        end
    endgenerate
endmodule

// File: rtl/mul_lane.sv
// One exact W x W multiply with per-operand signedness.
// Each operand gets one extra bit (its sign or zero), and is then widened to
// the product width; the low 2W bits of that product are exact for all four
// sign combinations.
module mul_lane #(
    parameter int W = 18,
    localparam int PW = 2 * W
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          sa_i,
    input  logic          sb_i,
    output logic [PW-1:0] p_o
);
    logic          a_top, b_top;
    logic [PW-1:0] a_ext, b_ext;

    always_comb begin
        a_top = sa_i & a_i[W-1];
        b_top = sb_i & b_i[W-1];
        a_ext = {{W{a_top}}, a_i};
        b_ext = {{W{b_top}}, b_i};
        p_o   = a_ext * b_ext;
    end
endmodule

// File: rtl/mul_core.sv
// Arranges lanes as one wide multiplier or as two half-width multipliers.
module mul_core #(
    parameter int                      W    = 18,
    parameter mul_slice_pkg::mul_mode_e MODE = mul_slice_pkg::MODE_WIDE,
    localparam int PW = 2 * W
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          sa_i,
    input  logic          sb_i,
    output logic [PW-1:0] p_o
);
    localparam int NLANE = (MODE == mul_slice_pkg::MODE_SPLIT) ? 2 : 1;
    localparam int LW    = W / NLANE;

    generate
        for (genvar l = 0; l < NLANE; l++) begin : g_lane
            mul_lane #(.W(LW)) u_lane (
                .a_i  (a_i[l*LW +: LW]),
                .b_i  (b_i[l*LW +: LW]),
                .sa_i (sa_i),
                .sb_i (sb_i),
                .p_o  (p_o[l*2*LW +: 2*LW])
            );
        end
    endgenerate
endmodule

// File: rtl/mul_out_reg.sv
// Optional output register built from NSEC equal sections.
module mul_out_reg #(
    parameter int PW       = 36,
    parameter int NSEC     = 1,
    parameter bit REGISTER = 1'b1
) (
    input  logic          clk_i,
    input  logic          clr_i,
    input  logic          ena_i,
    input  logic [PW-1:0] p_i,
    output logic [PW-1:0] p_o
);
    localparam int SW = PW / NSEC;

    generate
        if (REGISTER) begin : g_reg
            for (genvar s = 0; s < NSEC; s++) begin : g_sec
                logic [SW-1:0] sec_d, sec_q;

                always_comb begin
                    sec_d = ena_i ? p_i[s*SW +: SW] : sec_q;
                end

                always_ff @(posedge clk_i or posedge clr_i) begin
                    if (clr_i) sec_q <= '0;
                    else       sec_q <= sec_d;
                end

                assign p_o[s*SW +: SW] = sec_q;
            end
        end else begin : g_bypass
            assign p_o = p_i;
        end
    endgenerate
endmodule

// File: rtl/mul_slice.sv
// Top of the mixed-sign multiplier slice.
module mul_slice #(
    parameter int                      OP_W     = mul_slice_pkg::OP_W,
    parameter mul_slice_pkg::mul_mode_e MODE     = mul_slice_pkg::MODE_WIDE,
    parameter bit                      REG_A    = 1'b1,
    parameter bit                      REG_B    = 1'b1,
    parameter bit                      REG_OUT  = 1'b1,
    parameter bit                      USE_SIGN = 1'b1,
    localparam int                     PROD_W   = 2 * OP_W
) (
    input  logic              clk_i,
    input  logic              clr_i,
    input  logic              ena_i,
    input  logic [OP_W-1:0]   a_i,
    input  logic [OP_W-1:0]   b_i,
    input  logic              a_signed_i,
    input  logic              b_signed_i,
    output logic [PROD_W-1:0] prod_o
);
    localparam int NSEC = (MODE == mul_slice_pkg::MODE_SPLIT) ? 2 : 1;

    logic              sa_in, sb_in;
    logic [OP_W-1:0]   a_m, b_m;
    logic              sa_m, sb_m;
    logic [PROD_W-1:0] p_raw;

    // Unused sign controls fall back to unsigned operands
    assign sa_in = USE_SIGN ? a_signed_i : 1'b0;
    assign sb_in = USE_SIGN ? b_signed_i : 1'b0;

    mul_in_reg #(.W(OP_W), .REGISTER(REG_A)) u_in_a (
        .clk_i  (clk_i),
        .clr_i  (clr_i),
        .ena_i  (ena_i),
        .data_i (a_i),
        .sgn_i  (sa_in),
        .data_o (a_m),
        .sgn_o  (sa_m)
    );

    mul_in_reg #(.W(OP_W), .REGISTER(REG_B)) u_in_b (
        .clk_i  (clk_i),
        .clr_i  (clr_i),
        .ena_i  (ena_i),
        .data_i (b_i),
        .sgn_i  (sb_in),
        .data_o (b_m),
        .sgn_o  (sb_m)
    );

    mul_core #(.W(OP_W), .MODE(MODE)) u_core (
        .a_i  (a_m),
        .b_i  (b_m),
        .sa_i (sa_m),
        .sb_i (sb_m),
        .p_o  (p_raw)
    );

    mul_out_reg #(.PW(PROD_W), .NSEC(NSEC), .REGISTER(REG_OUT)) u_out (
        .clk_i (clk_i),
        .clr_i (clr_i),
        .ena_i (ena_i),
        .p_i   (p_raw),
        .p_o   (prod_o)
    );
endmodule

// File: rtl/mul_slice_chk.sv
// Assertion checker for mul_slice, attached by bind.
module mul_slice_chk #(
    parameter int                      OP_W     = 18,
    parameter mul_slice_pkg::mul_mode_e MODE     = mul_slice_pkg::MODE_WIDE,
    parameter bit                      REG_A    = 1'b1,
    parameter bit                      REG_B    = 1'b1,
    parameter bit                      REG_OUT  = 1'b1,
    parameter bit                      USE_SIGN = 1'b1,
    localparam int                     PROD_W   = 2 * OP_W
) (
    input logic              clk_i,
    input logic              clr_i,
    input logic              ena_i,
    input logic [OP_W-1:0]   a_i,
    input logic [OP_W-1:0]   b_i,
    input logic              a_signed_i,
    input logic              b_signed_i,
    input logic [PROD_W-1:0] prod_o
);
    localparam bit NO_REGS = !REG_A && !REG_B && !REG_OUT;

    generate
        if (REG_OUT) begin : g_out
            // R7: a registered product reads zero during clear
            a_r7_clear_zero: assert property (@(posedge clk_i)
                clr_i |-> prod_o == '0);

            // R6: the output register holds while the enable is low
            a_r6_hold: assert property (@(posedge clk_i) disable iff (clr_i)
                !ena_i |=> $stable(prod_o));
        end

        if (NO_REGS) begin : g_comb
            // R9: a zero operand gives a zero product
            a_r9_zero_operand: assert property (@(posedge clk_i) disable iff (clr_i)
                (a_i == '0 || b_i == '0) |-> prod_o == '0);

            if (MODE == mul_slice_pkg::MODE_WIDE) begin : g_wide
                logic [PROD_W-1:0] ua, ub;
                assign ua = {{OP_W{1'b0}}, a_i};
                assign ub = {{OP_W{1'b0}}, b_i};

                // R1: both controls low means a plain unsigned product
                a_r1_unsigned: assert property (@(posedge clk_i) disable iff (clr_i)
                    (!a_signed_i && !b_signed_i) |-> prod_o == ua * ub);

                if (!USE_SIGN) begin : g_nosign
                    // R8: sign inputs are ignored when unused
                    a_r8_ignored_sign: assert property (@(posedge clk_i) disable iff (clr_i)
                        1'b1 |-> prod_o == ua * ub);
                end
            end
        end
    endgenerate
endmodule

bind mul_slice mul_slice_chk #(
    .OP_W     (OP_W),
    .MODE     (MODE),
    .REG_A    (REG_A),
    .REG_B    (REG_B),
    .REG_OUT  (REG_OUT),
    .USE_SIGN (USE_SIGN)
) u_mul_slice_chk (
    .clk_i      (clk_i),
    .clr_i      (clr_i),
    .ena_i      (ena_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .a_signed_i (a_signed_i),
    .b_signed_i (b_signed_i),
    .prod_o     (prod_o)
);

// File: tb/test_mul_slice.sv
module test_mul_slice;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        clr;
    logic        ena;
    logic [17:0] a, b;
    logic        sa, sb;
    logic [35:0] p_full, p_split, p_comb;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Wide mode, both inputs and output registered: latency 2
    mul_slice #(.MODE(mul_slice_pkg::MODE_WIDE), .REG_A(1'b1), .REG_B(1'b1),
                .REG_OUT(1'b1), .USE_SIGN(1'b1)) i_mul_slice (
        .clk_i(clk), .clr_i(clr), .ena_i(ena), .a_i(a), .b_i(b),
        .a_signed_i(sa), .b_signed_i(sb), .prod_o(p_full));

    // Split mode, only A registered, no output register
    mul_slice #(.MODE(mul_slice_pkg::MODE_SPLIT), .REG_A(1'b1), .REG_B(1'b0),
                .REG_OUT(1'b0), .USE_SIGN(1'b1)) i_mul_slice_split (
        .clk_i(clk), .clr_i(clr), .ena_i(ena), .a_i(a), .b_i(b),
        .a_signed_i(sa), .b_signed_i(sb), .prod_o(p_split));

    // Wide mode, no registers, sign controls unused
    mul_slice #(.MODE(mul_slice_pkg::MODE_WIDE), .REG_A(1'b0), .REG_B(1'b0),
                .REG_OUT(1'b0), .USE_SIGN(1'b0)) i_mul_slice_comb (
        .clk_i(clk), .clr_i(clr), .ena_i(ena), .a_i(a), .b_i(b),
        .a_signed_i(sa), .b_signed_i(sb), .prod_o(p_comb));

    function automatic logic [35:0] exp_wide(logic [17:0] x, logic [17:0] y,
                                             logic sx, logic sy);
        logic [35:0] xe, ye;
        xe = {{18{sx & x[17]}}, x};
        ye = {{18{sy & y[17]}}, y};
        return xe * ye;
    endfunction

    function automatic logic [17:0] exp_lane(logic [8:0] x, logic [8:0] y,
                                             logic sx, logic sy);
        logic [17:0] xe, ye;
        xe = {{9{sx & x[8]}}, x};
        ye = {{9{sy & y[8]}}, y};
        return xe * ye;
    endfunction

    function automatic logic [35:0] exp_split(logic [17:0] x, logic [17:0] y,
                                              logic sx, logic sy);
        return {exp_lane(x[17:9], y[17:9], sx, sy), exp_lane(x[8:0], y[8:0], sx, sy)};
    endfunction

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [17:0] x, logic [17:0] y, logic sx, logic sy);
        @(negedge clk);
        a = x; b = y; sa = sx; sb = sy;
    endtask

    task automatic settle2;
        @(posedge clk); @(posedge clk); #1;
    endtask

    task automatic t_reset;
        a = 18'h3ffff; b = 18'h3ffff; sa = 1'b1; sb = 1'b0; ena = 1'b1;
        clr = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R7 reset full", p_full, 36'h0);
        check("R7 reset split", p_split, 36'h0);
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_wide_combos;
        logic [17:0] va[5] = '{18'h20000, 18'h3ffff, 18'h12345, 18'h3ffff, 18'h1ffff};
        logic [17:0] vb[5] = '{18'h20000, 18'h3ffff, 18'h2abcd, 18'h00001, 18'h20000};
        for (int i = 0; i < 5; i++) begin
            for (int s = 0; s < 4; s++) begin
                drive(va[i], vb[i], s[1], s[0]);
                #1;
                check("R8 unused signs", p_comb, exp_wide(va[i], vb[i], 1'b0, 1'b0));
                settle2();
                check("R1 R2 wide product", p_full, exp_wide(va[i], vb[i], s[1], s[0]));
            end
        end
    endtask

    task automatic t_latency;
        drive(18'h00003, 18'h00005, 1'b0, 1'b0);
        settle2();
        drive(18'h3fffe, 18'h00007, 1'b1, 1'b0);
        @(posedge clk); #1;
        check("R5 old value after 1 edge", p_full, 36'd15);
        @(posedge clk); #1;
        check("R5 new value after 2 edges", p_full, exp_wide(18'h3fffe, 18'h7, 1'b1, 1'b0));
        // sign control travels with its operand
        drive(18'h3fffe, 18'h00007, 1'b0, 1'b0);
        @(posedge clk); #1;
        check("R4 sign aligned, old", p_full, exp_wide(18'h3fffe, 18'h7, 1'b1, 1'b0));
        @(posedge clk); #1;
        check("R4 sign aligned, new", p_full, exp_wide(18'h3fffe, 18'h7, 1'b0, 1'b0));
    endtask

    task automatic t_split;
        logic [17:0] xa = {9'h1ff, 9'h100};
        logic [17:0] xb = {9'h003, 9'h0ff};
        for (int s = 0; s < 4; s++) begin
            drive(xa, xb, s[1], s[0]);
            @(posedge clk); #1;
            check("R3 split lanes", p_split, exp_split(xa, xb, s[1], s[0]));
        end
        // R4: bypassed B is seen at once, registered A only after an edge
        @(negedge clk);
        b = {9'h005, 9'h002};
        #1;
        check("R4 bypassed B immediate", p_split, exp_split(xa, b, 1'b1, 1'b1));
        @(negedge clk);
        a = {9'h002, 9'h003};
        #1;
        check("R4 registered A waits", p_split, exp_split(xa, b, 1'b1, 1'b1));
        @(posedge clk); #1;
        check("R4 registered A after edge", p_split, exp_split(a, b, 1'b1, 1'b1));
    endtask

    task automatic t_enable;
        drive(18'h00011, 18'h00022, 1'b0, 1'b0);
        settle2();
        @(negedge clk);
        ena = 1'b0;
        a = 18'h3ffff; b = 18'h3ffff; sa = 1'b1; sb = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R6 hold full", p_full, 36'h242);
        check("R6 hold split regA", p_split,
              exp_split(18'h00011, 18'h3ffff, 1'b0, 1'b1));
        @(negedge clk);
        ena = 1'b1;
        settle2();
        check("R6 resume", p_full, 36'h1);
    endtask

    task automatic t_clear;
        drive(18'h1234, 18'h0567, 1'b0, 1'b0);
        settle2();
        @(negedge clk);
        clr = 1'b1;
        #1;
        check("R7 async clear full", p_full, 36'h0);
        check("R7 async clear split", p_split, 36'h0);
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_zero;
        for (int s = 0; s < 4; s++) begin
            drive(18'h0, 18'h3ffff, s[1], s[0]);
            #1;
            check("R9 zero comb", p_comb, 36'h0);
            settle2();
            check("R9 zero full", p_full, 36'h0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_wide_combos();
        t_latency();
        t_split();
        t_enable();
        t_clear();
        t_zero();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule